// File: doc/BRIEF.md
# Constant-Correction Two-Input Max-Star Unit

This combinational unit approximates the Jacobian logarithm of two signed fixed-point metrics. It returns the larger of its two inputs, raised by a fixed correction of 3/8 whenever the inputs sit closer together than 2.0. Otherwise it returns the larger input unchanged. No lookup table or sloped correction is used. The whole cost of the correction is one closeness test on the difference and one small constant adder.

Both inputs are DATA_W-bit two's complement words with three fractional bits, so one LSB weighs 1/8. The result is one bit wider, so that the correction can never wrap. The cell is meant to be placed recursively as the leaf of an n-input max-star tree in a soft-decision decoder. DATA_W is a parameter and is exercised at 8, 12 and 16.

Top module: `maxstar_const_unit`

## Requirements
- R1: When the true difference a - b lies strictly between -16 and +16 LSBs (between -2.0 and +2.0), out_z equals max(a, b) + 3 LSBs (3/8).
- R2: When |a - b| is 16 LSBs (2.0) or more, out_z equals max(a, b) with no correction.
- R3: A difference of exactly +16 or -16 LSBs gives no correction. A difference of exactly +15 or -15 LSBs (±15/8) gives the +3 LSB correction.
- R4: Equal inputs give out_z = a + 3 LSBs. This includes a = b = 0, which gives 3.
- R5: out_z is a signed DATA_W+1 bit value and never overflows. For a = b = 2^(DATA_W-1)-1 it equals 2^(DATA_W-1)+2. For a = b = -2^(DATA_W-1) it equals -2^(DATA_W-1)+3.
- R6: The difference is formed without wrap over the full input range. For a = +max and b = -max-1, out_z equals +max with no correction, and the same holds with the inputs swapped.
- R7: The result is symmetric: swapping a and b never changes out_z.
- R8: Behaviour R1 to R7 holds for DATA_W of 8, 12 and 16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| in_a | input | DATA_W | First metric, two's complement, 3 fractional bits |
| in_b | input | DATA_W | Second metric, two's complement, 3 fractional bits |
| out_z | output | DATA_W+1 | Larger metric plus the optional 3/8 correction, two's complement |

## Verification
The assertions assume that both inputs are stable, fully driven two's complement words when the combinational checks evaluate, and that the fraction width is three bits. They also assume that the only legal excess of the output over the larger input is 0 or 3 LSBs. The stimulus keeps to this by driving every input from whole DATA_W-bit values: all input pairs at 8 bits, seeded random pairs at 12 and 16 bits, and directed pairs at differences of 0, ±15, ±16 and at both range extremes. Each pair is held for several time units before the output is compared.

// File: rtl/maxstar_pkg.sv
package maxstar_pkg;

  // which operand the selector forwarded as the maximum
  typedef enum logic {
    PICK_A = 1'b0,
    PICK_B = 1'b1
  } pick_e;

  // correction of 3/8 expressed in LSBs for a given fraction width
  function automatic int unsigned corr_units(input int unsigned frac_w);
    return 32'd3 << (frac_w - 3);
  endfunction

  // bit position whose weight is 2.0
  function automatic int unsigned two_pos(input int unsigned frac_w);
    return frac_w + 1;
  endfunction

endpackage

// File: rtl/ms_diff.sv
module ms_diff #(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0]      op_a,
  input  logic [DATA_W-1:0]      op_b,
  output logic signed [DATA_W:0] diff_o
);
  localparam int DW = DATA_W + 1;

  // widen both operands by one sign bit, then subtract: no wrap is possible
  function automatic logic signed [DW-1:0] wide_sub(
    input logic [DATA_W-1:0] x,
    input logic [DATA_W-1:0] y
  );
    logic signed [DW-1:0] xe;
    logic signed [DW-1:0] ye;
    xe = {x[DATA_W-1], x};
    ye = {y[DATA_W-1], y};
    return xe - ye;
  endfunction

  always_comb diff_o = wide_sub(op_a, op_b);
endmodule

// File: rtl/ms_select.sv
module ms_select
  import maxstar_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0]      op_a,
  input  logic [DATA_W-1:0]      op_b,
  input  logic signed [DATA_W:0] diff_i,
  output logic [DATA_W-1:0]      max_o,
  output pick_e                  pick_o
);
  // a negative difference means b is the larger operand
  function automatic pick_e pick_from_sign(input logic signed [DATA_W:0] d);
    return d[DATA_W] ? PICK_B : PICK_A;
  endfunction

  always_comb begin
    pick_o = pick_from_sign(diff_i);
    max_o  = (pick_o == PICK_B) ? op_b : op_a;
  end
endmodule

// File: rtl/ms_near.sv
module ms_near
  import maxstar_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int FRAC_W = 3
) (
  input  logic signed [DATA_W:0] diff_i,
  output logic                   near_o
);
  localparam int TP = two_pos(FRAC_W);

  // upper bits of the difference, from the 2.0 weight to the sign
  logic [DATA_W-TP:0] upper_w;
  logic [TP-1:0]      lower_w;
  logic               pos_near_w;
  logic               neg_near_w;

  // non-negative and below 2.0: every bit from weight 2.0 upward is zero
  function automatic logic is_pos_near(input logic [DATA_W-TP:0] up);
    return ~|up;
  endfunction

  // negative and above -2.0: upper bits all ones, and not exactly -2.0
  function automatic logic is_neg_near(
    input logic [DATA_W-TP:0] up,
    input logic [TP-1:0]      lo
  );
    return (&up) & (|lo);
  endfunction

  always_comb begin
    upper_w    = diff_i[DATA_W:TP];
    lower_w    = diff_i[TP-1:0];
    pos_near_w = is_pos_near(upper_w);
    neg_near_w = is_neg_near(upper_w, lower_w);
    near_o     = pos_near_w | neg_near_w;
  end
endmodule

// File: rtl/maxstar_const_unit.sv
module maxstar_const_unit
  import maxstar_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int FRAC_W = 3
) (
  input  logic [DATA_W-1:0] in_a,
  input  logic [DATA_W-1:0] in_b,
  output logic [DATA_W:0]   out_z
);
  localparam int OW   = DATA_W + 1;
  localparam int CORR = int'(corr_units(FRAC_W));

  // internal events brought out by name
  logic signed [DATA_W:0] diff_w;
  logic [DATA_W-1:0]      max_w;
  pick_e                  pick_w;
  logic                   near_w;

  ms_diff #(.DATA_W(DATA_W)) diff_i (
    .op_a  (in_a),
    .op_b  (in_b),
    .diff_o(diff_w)
  );

  ms_select #(.DATA_W(DATA_W)) sel_i (
    .op_a  (in_a),
    .op_b  (in_b),
    .diff_i(diff_w),
    .max_o (max_w),
    .pick_o(pick_w)
  );

  ms_near #(.DATA_W(DATA_W), .FRAC_W(FRAC_W)) near_i (
    .diff_i(diff_w),
    .near_o(near_w)
  );

  // sign-extend the maximum by one bit, then add the constant if close
  function automatic logic [OW-1:0] add_corr(
    input logic [DATA_W-1:0] m,
    input logic              hit
  );
    logic [OW-1:0] me;
    logic [OW-1:0] ce;
    me = {m[DATA_W-1], m};
    ce = hit ? OW'(CORR) : '0;
    return me + ce;
  endfunction

  always_comb out_z = add_corr(max_w, near_w);
endmodule

// File: rtl/maxstar_chk.sv
module maxstar_chk #(
  parameter int DATA_W = 8
) (
  input logic [DATA_W-1:0] in_a,
  input logic [DATA_W-1:0] in_b,
  input logic [DATA_W:0]   out_z,
  input logic [DATA_W-1:0] max_w,
  input logic              near_w
);
  logic signed [DATA_W+1:0] ea;
  logic signed [DATA_W+1:0] eb;
  logic signed [DATA_W+1:0] em;
  logic signed [DATA_W+1:0] ez;
  logic signed [DATA_W+1:0] excess;

  always_comb begin
    ea     = {{2{in_a[DATA_W-1]}}, in_a};
    eb     = {{2{in_b[DATA_W-1]}}, in_b};
    em     = {{2{max_w[DATA_W-1]}}, max_w};
    ez     = {out_z[DATA_W], out_z};
    excess = ez - em;

    // R2, R7: the forwarded maximum is one of the inputs and not below either
    a_r2_max_is_input: assert ((max_w == in_a || max_w == in_b) && em >= ea && em >= eb)
      else $error("max_w is not the larger input");
    // R1: a close pair adds exactly three LSBs to the maximum
    a_r1_near_adds_three: assert (!near_w || excess == 3)
      else $error("near pair excess %0d", excess);
    // R2: a distant pair leaves the maximum unchanged
    a_r2_far_no_corr: assert (near_w || excess == 0)
      else $error("far pair excess %0d", excess);
    // R4: identical inputs always take the correction
    a_r4_equal_corrected: assert (in_a != in_b || ez == ea + 3)
      else $error("equal inputs not corrected");
    // R5: the widened result is never below either input
    a_r5_no_overflow: assert (ez >= ea && ez >= eb)
      else $error("result wrapped");
  end
endmodule

bind maxstar_const_unit maxstar_chk #(.DATA_W(DATA_W)) chk_i (
  .in_a  (in_a),
  .in_b  (in_b),
  .out_z (out_z),
  .max_w (max_w),
  .near_w(near_w)
);

// File: tb/maxstar_const_unit_tb_top.sv
module maxstar_const_unit_tb_top;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  logic [7:0]  a8,  b8;
  logic [8:0]  z8;
  logic [11:0] a12, b12;
  logic [12:0] z12;
  logic [15:0] a16, b16;
  logic [16:0] z16;

  maxstar_const_unit #(.DATA_W(8))  dut_i     (.in_a(a8),  .in_b(b8),  .out_z(z8));
  maxstar_const_unit #(.DATA_W(12)) dut_w12_i (.in_a(a12), .in_b(b12), .out_z(z12));
  maxstar_const_unit #(.DATA_W(16)) dut_w16_i (.in_a(a16), .in_b(b16), .out_z(z16));

  // expected result from the requirements, in plain integers
  function automatic int model(input int a, input int b);
    int d;
    int m;
    d = a - b;
    m = (a > b) ? a : b;
    return (d > -16 && d < 16) ? m + 3 : m;
  endfunction

  function automatic string tag_for(input int a, input int b);
    int d;
    d = a - b;
    return (d > -16 && d < 16) ? "R1" : "R2";
  endfunction

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run(input int w, input int a, input int b, input string req);
    int act;
    case (w)
      8:  begin a8  = 8'(a);  b8  = 8'(b);  end
      12: begin a12 = 12'(a); b12 = 12'(b); end
      default: begin a16 = 16'(a); b16 = 16'(b); end
    endcase
    #2;
    case (w)
      8:  act = int'($signed(z8));
      12: act = int'($signed(z12));
      default: act = int'($signed(z16));
    endcase
    check(req, act, model(a, b));
  endtask

  task automatic corners(input int w);
    int mx;
    int mn;
    mx = (1 << (w - 1)) - 1;
    mn = -(1 << (w - 1));
    run(w, 0, 0, "R4 zero");
    run(w, 40, 40, "R4 equal");
    run(w, 32, 16, "R3 diff +16");
    run(w, 16, 32, "R3 diff -16");
    run(w, 31, 16, "R3 diff +15");
    run(w, 16, 31, "R3 diff -15");
    run(w, -5, -20, "R3 diff +15 negative");
    run(w, -100, -84, "R3 diff -16 negative");
    run(w, mx, mx, "R5 max pair");
    check("R5 max pair value", model(mx, mx), (1 << (w - 1)) + 2);
    run(w, mn, mn, "R5 min pair");
    run(w, mx, mn, "R6 full span");
    run(w, mn, mx, "R6 full span swapped");
    run(w, mx, mx - 15, "R5 near top");
    run(w, mn + 15, mn, "R5 near bottom");
  endtask

  initial begin
    int act1;
    a8 = '0; b8 = '0; a12 = '0; b12 = '0; a16 = '0; b16 = '0;
    void'($urandom(32'h1d2c3b4a));
    #3;
    // R8: the same corner set at every width
    corners(8);
    corners(12);
    corners(16);
    // exhaustive at 8 bits: R1/R2 by difference
    for (int a = -128; a < 128; a++) begin
      for (int b = -128; b < 128; b++) begin
        run(8, a, b, tag_for(a, b));
      end
    end
    // random at 12 and 16 bits, with a symmetry check (R7)
    for (int k = 0; k < 3000; k++) begin
      int ra;
      int rb;
      int w;
      w  = (k % 2 == 0) ? 12 : 16;
      ra = (w == 12) ? int'($signed(12'($urandom))) : int'($signed(16'($urandom)));
      if (k % 3 == 0)
        rb = ra + int'($urandom_range(0, 40)) - 20;
      else
        rb = (w == 12) ? int'($signed(12'($urandom))) : int'($signed(16'($urandom)));
      if (rb > (1 << (w - 1)) - 1) rb = (1 << (w - 1)) - 1;
      if (rb < -(1 << (w - 1))) rb = -(1 << (w - 1));
      run(w, ra, rb, tag_for(ra, rb));
      act1 = (w == 12) ? int'($signed(z12)) : int'($signed(z16));
      run(w, rb, ra, "R7 swap");
      check("R7 swap equal", (w == 12) ? int'($signed(z12)) : int'($signed(z16)), act1);
    end
    if (!done) begin
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule